// File: doc/BRIEF.md
# Cylinder-Buffered Disk Bitstream Emulator

This block plays the drive side of a serial disk interface. One complete cylinder, meaning every head's track, sits in an on-chip bit array. The block sends the selected head's track to the controller as an unformatted serial bit stream. It also drives the bit clock the controller times itself from, and it marks the start of each revolution with an index pulse. The stream carries no sector framing. Whatever layout the controller wrote is replayed bit for bit, so any track format works. When the write gate is high, serial bits from the controller overwrite the selected track in place, and that head's dirty flag is raised.

Head selection only changes the upper part of the bit address. Switching heads therefore takes effect on the very next system clock, far inside the few microseconds a controller allows between selecting a head and opening the read gate. Only a seek needs help from outside. The host raises `seek_busy`, unloads any dirty tracks word by word, loads the new cylinder, clears the dirty flags and then lowers `seek_busy` again. The rotation keeps running throughout, as a spindle would.

Top module: `cyl_bitstream_drive`

## Requirements
- R1: `drive_clk` has a period of CLK_DIV system clocks and is high for the first CLK_DIV/2 of them. The bit position advances by one at the end of each period, which is the last cycle of the period.
- R2: The bit position counts 0 to TRACK_BITS-1 and then returns to 0. It is shared by all heads. `index_pulse` is high for exactly the one bit period in which the position is 0, and it starts right after position TRACK_BITS-1.
- R3: If `wr_gate` is high and `seek_busy` is low in the last cycle of a bit period, `wr_data` is stored at bit address head*TRACK_BITS+position. Bit b of host word w is bit address w*WORD_W+b.
- R4: In every cycle `rd_data` shows the stored bit at the head and position of the previous cycle, if `rd_gate` was high and `seek_busy` was low in that cycle. Otherwise it shows 0. A bit written on a clock edge reads back its old value on that same edge.
- R5: A change of `head` shows in `rd_data` on the next clock, with no dead time.
- R6: A drive-side store as in R3 sets `dirty[head]` on the same edge. The flag stays set until the host clears it.
- R7: While `seek_busy` is high, drive-side writes do not happen, `rd_data` is 0 from the next cycle on, and `ready` goes low one cycle later. `ready` goes high one cycle after `seek_busy` falls.
- R8: While `seek_busy` is high, `hst_we` writes `hst_wdata` into word `hst_addr`, and `hst_re` loads that word's old contents into `hst_rdata` one cycle later. `hst_clr` clears every dirty flag whose bit is set in `hst_clr_mask`. While `seek_busy` is low, all three host commands are ignored and `hst_rdata` holds its value.
- R9: While `rst_n` is low at a clock edge, the bit position and the divider return to 0, and `rd_data`, `ready`, `dirty` and `hst_rdata` become 0. The stored bits are left alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| head | input | HEAD_W | Selected head |
| rd_gate | input | 1 | Controller read gate |
| wr_gate | input | 1 | Controller write gate |
| wr_data | input | 1 | Serial write bit, sampled at the end of each bit period |
| seek_busy | input | 1 | Host owns the buffer; the drive side is frozen |
| hst_we | input | 1 | Host word write |
| hst_re | input | 1 | Host word read |
| hst_addr | input | WADDR_W | Host word address |
| hst_wdata | input | WORD_W | Host write word |
| hst_clr | input | 1 | Clear the dirty flags selected by the mask |
| hst_clr_mask | input | NUM_HEADS | One bit per head to clear |
| rd_data | output | 1 | Serial read bit |
| drive_clk | output | 1 | Bit clock sent to the controller |
| index_pulse | output | 1 | High during bit position 0 |
| ready | output | 1 | Drive is available to the controller |
| dirty | output | NUM_HEADS | Per-track written flags |
| hst_rdata | output | WORD_W | Host read word |

## Verification
Two drive-side functions can fall on the same clock edge. The first is a store of a written bit, which happens on the last cycle of a bit period. The second is the read of that same bit for the serial stream. The bench keeps both gates high while writing a pseudo-random pattern, so every store edge is also a read edge. The behavioural model requires the old value on that edge and the new value only after the next full revolution. The bench also switches heads in the middle of a bit period and across the index wrap, so that a head change can land on a store edge. Both the dirty flag and the stored bit are then judged against the head that was selected on that edge.

// File: rtl/cbd_pkg.sv
// Shared definitions for the cylinder bitstream emulator.
// Assumes: nothing beyond standard SystemVerilog.
package cbd_pkg;

    // Which side currently owns the cylinder buffer.
    typedef enum logic {
        OWN_DRIVE = 1'b0,
        OWN_HOST  = 1'b1
    } owner_e;

    // Next bit position with wrap at the track end.
    function automatic int unsigned next_pos(input int unsigned pos, input int unsigned track_bits);
        return (pos == track_bits - 1) ? 0 : pos + 1;
    endfunction

endpackage

// File: rtl/cbd_bit_timer.sv
// Bit timer: divides the system clock into bit periods, keeps the rotating
// bit position and derives the drive clock and the index mark.
// Assumes: CLK_DIV >= 2 and even, TRACK_BITS a power of two >= 2.
module cbd_bit_timer #(
    parameter int TRACK_BITS = 64,
    parameter int CLK_DIV    = 4,
    localparam int POS_W     = $clog2(TRACK_BITS),
    localparam int CNT_W     = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             bit_tick,
    output logic [POS_W-1:0] bit_pos,
    output logic             drive_clk,
    output logic             index_mark
);
    import cbd_pkg::*;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CLK_DIV / 2);

    logic [CNT_W-1:0] div_cnt;

    // End of a bit period and the two derived outputs.
    always_comb begin
        bit_tick   = (div_cnt == CNT_LAST);
        drive_clk  = (div_cnt < CNT_HALF);
        index_mark = (bit_pos == '0);
    end

    // Divider counter for one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_cnt <= '0;
        else if (bit_tick) div_cnt <= '0;
        else               div_cnt <= div_cnt + 1'b1;
    end

    // Rotating position, shared by all heads.
    always_ff @(posedge clk) begin
        if (!rst_n)        bit_pos <= '0;
        else if (bit_tick) bit_pos <= POS_W'(next_pos(32'(bit_pos), TRACK_BITS));
    end

endmodule

// File: rtl/cbd_track_ram.sv
// Cylinder buffer: a bit array with a bit-wide drive port and a word-wide
// host port. The owner input chooses which port may act in a cycle.
// Assumes: NUM_HEADS, TRACK_BITS and WORD_W are powers of two, WORD_W >= 2,
// TRACK_BITS >= WORD_W. The contents are not reset.
module cbd_track_ram #(
    parameter int NUM_HEADS  = 4,
    parameter int TRACK_BITS = 64,
    parameter int WORD_W     = 8,
    localparam int HEAD_W    = $clog2(NUM_HEADS),
    localparam int POS_W     = $clog2(TRACK_BITS),
    localparam int BADDR_W   = HEAD_W + POS_W,
    localparam int BIDX_W    = $clog2(WORD_W),
    localparam int WORDS     = NUM_HEADS * TRACK_BITS / WORD_W,
    localparam int WADDR_W   = $clog2(WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  cbd_pkg::owner_e     owner,
    input  logic [HEAD_W-1:0]   drv_head,
    input  logic [POS_W-1:0]    drv_pos,
    input  logic                drv_re,
    input  logic                drv_we,
    input  logic                drv_wbit,
    output logic                drv_rbit,
    input  logic                hst_we,
    input  logic                hst_re,
    input  logic [WADDR_W-1:0]  hst_addr,
    input  logic [WORD_W-1:0]   hst_wdata,
    output logic [WORD_W-1:0]   hst_rdata
);
    import cbd_pkg::*;

    logic [WORD_W-1:0]  mem [WORDS];
    logic [BADDR_W-1:0] bit_addr;
    logic [WADDR_W-1:0] drv_word;
    logic [BIDX_W-1:0]  drv_bidx;
    logic               drv_act_we;
    logic               drv_act_re;
    logic               hst_act_we;
    logic               hst_act_re;

    // Head in the high bits, so a head change only moves the upper address.
    always_comb begin
        bit_addr   = {drv_head, drv_pos};
        drv_word   = bit_addr[BADDR_W-1:BIDX_W];
        drv_bidx   = bit_addr[BIDX_W-1:0];
        drv_act_we = (owner == OWN_DRIVE) && drv_we;
        drv_act_re = (owner == OWN_DRIVE) && drv_re;
        hst_act_we = (owner == OWN_HOST) && hst_we;
        hst_act_re = (owner == OWN_HOST) && hst_re;
    end

    // Storage writes from whichever side owns the buffer.
    always_ff @(posedge clk) begin
        if (drv_act_we)      mem[drv_word][drv_bidx] <= drv_wbit;
        else if (hst_act_we) mem[hst_addr]           <= hst_wdata;
    end

    // Registered serial read; gives zero when the drive side is not reading.
    always_ff @(posedge clk) begin
        if (!rst_n)          drv_rbit <= 1'b0;
        else if (drv_act_re) drv_rbit <= mem[drv_word][drv_bidx];
        else                 drv_rbit <= 1'b0;
    end

    // Registered host word read; holds its value between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)          hst_rdata <= '0;
        else if (hst_act_re) hst_rdata <= mem[hst_addr];
    end

endmodule

// File: rtl/cbd_dirty_track.sv
// Per-head dirty flags: set by a drive-side store, cleared by a host mask.
// Assumes: set and clear never fall in the same cycle (different owners).
module cbd_dirty_track #(
    parameter int NUM_HEADS = 4,
    localparam int HEAD_W   = $clog2(NUM_HEADS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_en,
    input  logic [HEAD_W-1:0]    set_head,
    input  logic                 clr_en,
    input  logic [NUM_HEADS-1:0] clr_mask,
    output logic [NUM_HEADS-1:0] dirty
);

    for (genvar h = 0; h < NUM_HEADS; h++) begin : g_flag
        // One flag per track of the cylinder.
        always_ff @(posedge clk) begin
            if (!rst_n)                                        dirty[h] <= 1'b0;
            else if (set_en && (set_head == HEAD_W'(h)))       dirty[h] <= 1'b1;
            else if (clr_en && clr_mask[h])                    dirty[h] <= 1'b0;
        end
    end

endmodule

// File: rtl/cyl_bitstream_drive.sv
// Top of the cylinder bitstream emulator. Streams the selected head's track
// as raw bits with a drive-made clock and index, stores controller writes,
// flags written tracks, and lends the buffer to the host during a seek.
// Assumes: parameters as in cbd_track_ram and cbd_bit_timer.
module cyl_bitstream_drive #(
    parameter int NUM_HEADS  = 4,
    parameter int TRACK_BITS = 64,
    parameter int WORD_W     = 8,
    parameter int CLK_DIV    = 4,
    localparam int HEAD_W    = $clog2(NUM_HEADS),
    localparam int POS_W     = $clog2(TRACK_BITS),
    localparam int WORDS     = NUM_HEADS * TRACK_BITS / WORD_W,
    localparam int WADDR_W   = $clog2(WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HEAD_W-1:0]    head,
    input  logic                 rd_gate,
    input  logic                 wr_gate,
    input  logic                 wr_data,
    input  logic                 seek_busy,
    input  logic                 hst_we,
    input  logic                 hst_re,
    input  logic [WADDR_W-1:0]   hst_addr,
    input  logic [WORD_W-1:0]    hst_wdata,
    input  logic                 hst_clr,
    input  logic [NUM_HEADS-1:0] hst_clr_mask,
    output logic                 rd_data,
    output logic                 drive_clk,
    output logic                 index_pulse,
    output logic                 ready,
    output logic [NUM_HEADS-1:0] dirty,
    output logic [WORD_W-1:0]    hst_rdata
);
    import cbd_pkg::*;

    owner_e           owner;
    logic             bit_tick;
    logic [POS_W-1:0] bit_pos;
    logic             store_bit;

    // Ownership and the drive-side store strobe.
    always_comb begin
        owner     = seek_busy ? OWN_HOST : OWN_DRIVE;
        store_bit = bit_tick && wr_gate && !seek_busy;
    end

    // Ready is the registered inverse of the seek hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= 1'b0;
        else        ready <= !seek_busy;
    end

    cbd_bit_timer #(
        .TRACK_BITS (TRACK_BITS),
        .CLK_DIV    (CLK_DIV)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .bit_pos    (bit_pos),
        .drive_clk  (drive_clk),
        .index_mark (index_pulse)
    );

    cbd_track_ram #(
        .NUM_HEADS  (NUM_HEADS),
        .TRACK_BITS (TRACK_BITS),
        .WORD_W     (WORD_W)
    ) u_ram (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .drv_head   (head),
        .drv_pos    (bit_pos),
        .drv_re     (rd_gate),
        .drv_we     (store_bit),
        .drv_wbit   (wr_data),
        .drv_rbit   (rd_data),
        .hst_we     (hst_we),
        .hst_re     (hst_re),
        .hst_addr   (hst_addr),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata)
    );

    cbd_dirty_track #(
        .NUM_HEADS  (NUM_HEADS)
    ) u_dirty (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (store_bit),
        .set_head   (head),
        .clr_en     (hst_clr && seek_busy),
        .clr_mask   (hst_clr_mask),
        .dirty      (dirty)
    );

endmodule

// File: rtl/cbd_checker.sv
// Temporal checks for cyl_bitstream_drive, attached by bind below.
module cbd_checker #(
    parameter int NUM_HEADS  = 4,
    parameter int TRACK_BITS = 64,
    parameter int WORD_W     = 8,
    localparam int HEAD_W    = $clog2(NUM_HEADS),
    localparam int POS_W     = $clog2(TRACK_BITS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [HEAD_W-1:0]    head,
    input logic                 rd_gate,
    input logic                 wr_gate,
    input logic                 seek_busy,
    input logic                 bit_tick,
    input logic [POS_W-1:0]     bit_pos,
    input logic                 drive_clk,
    input logic                 index_pulse,
    input logic                 rd_data,
    input logic                 ready,
    input logic [NUM_HEADS-1:0] dirty,
    input logic [WORD_W-1:0]    hst_rdata
);

    // R1: position only moves after a period end; the period ends in the low half.
    assert_pos_moves_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_pos != $past(bit_pos)) |-> $past(bit_tick));
    assert_tick_in_low_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> !drive_clk);

    // R2: index begins only right after the last position.
    assert_index_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_pulse) |-> ($past(bit_pos) == POS_W'(TRACK_BITS - 1)));

    // R4: a closed read gate gives a zero bit next cycle.
    assert_closed_gate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_gate |=> !rd_data);

    // R6: a drive store marks the selected head.
    assert_store_marks_dirty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && wr_gate && !seek_busy) |=> dirty[$past(head)]);

    // R7: during a seek no flag rises, the stream is silent, ready follows.
    assert_seek_no_new_dirty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seek_busy |=> ((dirty & ~$past(dirty)) == '0));
    assert_seek_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seek_busy |=> !rd_data);
    assert_ready_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        seek_busy |=> !ready);
    assert_ready_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !seek_busy |=> ready);

    // R8: host read data holds while the drive side owns the buffer.
    assert_host_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !seek_busy |=> $stable(hst_rdata));

endmodule

bind cyl_bitstream_drive cbd_checker #(
    .NUM_HEADS  (NUM_HEADS),
    .TRACK_BITS (TRACK_BITS),
    .WORD_W     (WORD_W)
) u_cbd_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .head        (head),
    .rd_gate     (rd_gate),
    .wr_gate     (wr_gate),
    .seek_busy   (seek_busy),
    .bit_tick    (bit_tick),
    .bit_pos     (bit_pos),
    .drive_clk   (drive_clk),
    .index_pulse (index_pulse),
    .rd_data     (rd_data),
    .ready       (ready),
    .dirty       (dirty),
    .hst_rdata   (hst_rdata)
);

// File: tb/test_cyl_bitstream_drive.sv
`timescale 1ns/1ps
module test_cyl_bitstream_drive;
    localparam int NH  = 4;
    localparam int TB  = 64;
    localparam int WW  = 8;
    localparam int DIV = 4;
    localparam int NW  = NH * TB / WW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    head = '0;
    logic          rd_gate = 1'b0, wr_gate = 1'b0, wr_data = 1'b0, seek_busy = 1'b0;
    logic          hst_we = 1'b0, hst_re = 1'b0, hst_clr = 1'b0;
    logic [4:0]    hst_addr = '0;
    logic [WW-1:0] hst_wdata = '0;
    logic [NH-1:0] hst_clr_mask = '0;
    logic          rd_data, drive_clk, index_pulse, ready;
    logic [NH-1:0] dirty;
    logic [WW-1:0] hst_rdata;

    int checks = 0, errors = 0;
    bit cmp_on = 0, done = 0;

    // Behavioural reference state.
    bit          m_mem [NH*TB];
    int          m_cnt, m_pos;
    bit          m_rd, m_ready;
    bit [NH-1:0] m_dirty;
    bit [WW-1:0] m_hrd;

    always #2.5 clk = ~clk;

    cyl_bitstream_drive i_cyl_bitstream_drive (
        .clk(clk), .rst_n(rst_n), .head(head), .rd_gate(rd_gate), .wr_gate(wr_gate),
        .wr_data(wr_data), .seek_busy(seek_busy), .hst_we(hst_we), .hst_re(hst_re),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_clr(hst_clr),
        .hst_clr_mask(hst_clr_mask), .rd_data(rd_data), .drive_clk(drive_clk),
        .index_pulse(index_pulse), .ready(ready), .dirty(dirty), .hst_rdata(hst_rdata));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit [WW-1:0] m_word(input int w);
        bit [WW-1:0] v;
        for (int b = 0; b < WW; b++) v[b] = m_mem[w*WW+b];
        return v;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pos = 0; m_rd = 0; m_ready = 0; m_dirty = '0; m_hrd = '0;
        end else begin
            bit tick;
            int a;
            tick = (m_cnt == DIV-1);
            a = int'(head)*TB + m_pos;
            m_rd = (rd_gate && !seek_busy) ? m_mem[a] : 1'b0;
            if (seek_busy && hst_re) m_hrd = m_word(int'(hst_addr));
            if (seek_busy && hst_we)
                for (int b = 0; b < WW; b++) m_mem[int'(hst_addr)*WW+b] = hst_wdata[b];
            if (seek_busy && hst_clr) m_dirty = m_dirty & ~hst_clr_mask;
            if (!seek_busy && tick && wr_gate) begin
                m_mem[a] = wr_data;
                m_dirty[head] = 1'b1;
            end
            m_ready = !seek_busy;
            m_cnt = tick ? 0 : m_cnt + 1;
            if (tick) m_pos = (m_pos == TB-1) ? 0 : m_pos + 1;
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk(drive_clk === (m_cnt < DIV/2), "R1 drive_clk", int'(drive_clk), int'(m_cnt < DIV/2));
            chk(index_pulse === (m_pos == 0), "R2 index_pulse", int'(index_pulse), int'(m_pos == 0));
            chk(rd_data === m_rd, "R4 R5 rd_data", int'(rd_data), int'(m_rd));
            chk(dirty === m_dirty, "R6 dirty", int'(dirty), int'(m_dirty));
            chk(ready === m_ready, "R7 ready", int'(ready), int'(m_ready));
            chk(hst_rdata === m_hrd, "R8 hst_rdata", int'(hst_rdata), int'(m_hrd));
        end
    end

    task automatic host_wr(input int a, input bit [WW-1:0] d);
        @(negedge clk); hst_we = 1; hst_addr = 5'(a); hst_wdata = d;
        @(negedge clk); hst_we = 0;
    endtask

    task automatic host_rd(input int a, input bit [WW-1:0] exp, input string req);
        @(negedge clk); hst_re = 1; hst_addr = 5'(a);
        @(negedge clk); hst_re = 0;
        chk(hst_rdata === exp, req, int'(hst_rdata), int'(exp));
    endtask

    function automatic bit [WW-1:0] pat(input int w);
        return 8'(w * 37 + 5) ^ 8'h5A;
    endfunction

    initial begin
        bit [15:0] lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R9: reset values.
        chk(rd_data === 1'b0, "R9 rd_data", int'(rd_data), 0);
        chk(ready === 1'b0, "R9 ready", int'(ready), 0);
        chk(dirty === '0, "R9 dirty", int'(dirty), 0);
        chk(hst_rdata === '0, "R9 hst_rdata", int'(hst_rdata), 0);
        chk(index_pulse === 1'b1 && drive_clk === 1'b1, "R9 position", int'({index_pulse, drive_clk}), 3);
        cmp_on = 1;
        rst_n = 1;
        // R8: load the whole cylinder during a seek.
        seek_busy = 1;
        for (int w = 0; w < NW; w++) host_wr(w, pat(w));
        host_rd(0, pat(0), "R8 load word 0");
        host_rd(NW-1, pat(NW-1), "R8 load last word");
        @(negedge clk); hst_clr = 1; hst_clr_mask = '1;
        @(negedge clk); hst_clr = 0;
        seek_busy = 0;
        // R8: host write while the drive owns the buffer is ignored.
        host_wr(5, 8'hFF);
        // R4: full revolution of head 0.
        rd_gate = 1; head = 0;
        repeat (TB*DIV + 10) @(negedge clk);
        // R5: head switches at arbitrary points inside bit periods.
        for (int k = 0; k < 60; k++) begin
            head = 2'(k % NH);
            repeat (1 + k % 3) @(negedge clk);
        end
        // R3 R4 R6: write head 2 while reading it, over more than one revolution.
        head = 2; wr_gate = 1;
        for (int i = 0; i < TB*DIV + TB*DIV/2; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_data = lfsr[0];
            if (i == 100) seek_busy = 1;   // R7: writes and reads frozen
            if (i == 125) seek_busy = 0;
            @(negedge clk);
        end
        // R6: a short write on head 3 across the index wrap.
        head = 3;
        repeat (3*DIV) begin
            wr_data = ~wr_data;
            @(negedge clk);
        end
        wr_gate = 0; head = 2;
        repeat (TB*DIV + 4) @(negedge clk);
        rd_gate = 0;
        repeat (4) @(negedge clk);
        // R3: host read back of the written track matches the bit placement.
        seek_busy = 1;
        for (int w = 2*TB/WW; w < 3*TB/WW; w++) host_rd(w, m_word(w), "R3 head 2 word");
        host_rd(5, pat(5), "R8 ignored write");
        chk(dirty === 4'b1100, "R6 dirty heads", int'(dirty), 'hC);
        @(negedge clk); hst_clr = 1; hst_clr_mask = 4'b0100;
        @(negedge clk); hst_clr = 0;
        chk(dirty === 4'b1000, "R8 partial clear", int'(dirty), 'h8);
        seek_busy = 0;
        repeat (4) @(negedge clk);
        chk(ready === 1'b1, "R7 ready back", int'(ready), 1);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule